// File: doc/BRIEF.md
# Nested Loop Bytecode Profiler

This block sits beside the instruction fetch path of a bytecode processor and splits the count of fetched bytecodes by loop nesting level. Before a run, a host loads a small table of loops through a register-style port. Each loop entry holds its first and last address, the index of the loop that encloses it, and a valid bit. While profiling is enabled, every fetch strobe is compared against the loop start addresses of all valid entries at once. A single running counter follows the fetch stream.

When execution steps into a loop from the loop that encloses it, the running count is parked in the enclosing loop's local counter and counting restarts. When execution leaves the current loop, the count is added into that loop's global counter and the parked count is added back. As a result, each loop's global counter holds the bytecodes spent inside it, including those of all loops nested in it. After the run, with profiling disabled, the host reads the counters through the same port.

Top module: `loop_nest_profiler`

## Requirements
- R1: A fetch address matches an entry when the entry's valid bit (field code 5, bit 0) is set and the address equals its start address (field code 0). If several entries match, the lowest index wins. An entry whose valid bit is clear never matches.
- R2: While profiling is enabled, a fetch that neither enters nor leaves a loop raises `run_count` by one and leaves `cur_loop` unchanged. A cycle with no fetch strobe changes neither.
- R3: A fetch that matches entry h, where the predecessor of h (field code 2) equals `cur_loop` and h differs from `cur_loop`, is an entry into loop h. The old count goes into the local counter (field code 3) of the current loop, unless the current level is the method level. `run_count` becomes 1 and `cur_loop` becomes h.
- R4: A fetch of the current loop's start address starts a new iteration. It only adds one to the count, and it neither parks nor clears anything.
- R5: A match on an entry whose predecessor is not the current loop is counted as an ordinary fetch.
- R6: A fetch outside the current loop's inclusive range (start through end, field code 1) is an exit. The count goes into that loop's global counter (field code 4). `run_count` becomes count + the local counter of its predecessor + 1, and `cur_loop` moves to the predecessor. Exit is checked before any match, and one level is left per fetch.
- R7: The predecessor value of all ones marks the method level. `cur_loop` shows all ones there, and an exit to that level adds only one to the count.
- R8: All counters are 32 bits wide and saturate at all ones instead of wrapping.
- R9: While `prof_en` is low, `run_count` is 0, `cur_loop` is all ones, and fetch strobes are ignored.
- R10: Host writes take effect only while `prof_en` is low. A write made while profiling is enabled is ignored.
- R11: `cfg_rdata` returns the field selected by `cfg_idx`/`cfg_field`, zero-extended, one clock after that selection.
- R12: After reset, `run_count` is 0, `cur_loop` is all ones, and every entry is invalid. All addresses and counters are zero and every predecessor is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prof_en | input | 1 | Profiling enable; low allows host writes |
| fetch_valid | input | 1 | Bytecode fetch strobe |
| fetch_addr | input | ADDR_W (16) | Address of the fetched bytecode |
| cfg_we | input | 1 | Host write strobe |
| cfg_idx | input | LOG_ENTRIES (3) | Entry selected by the host |
| cfg_field | input | 3 | Field code: 0 start, 1 end, 2 pred, 3 local, 4 global, 5 valid |
| cfg_wdata | input | CNT_W (32) | Host write data |
| cfg_rdata | output | CNT_W (32) | Registered read data |
| run_count | output | CNT_W (32) | Running bytecode count |
| cur_loop | output | LOG_ENTRIES+1 (4) | Current loop index, all ones at method level |

## Verification
The hardest case to reach is a second visit to an inner loop from a middle loop that has already iterated. There, the parked middle-level count is no longer the one saved on the first entry, and an error in the restore arithmetic only shows up as a wrong total several exits later. The stimulus walks a three-deep nest with two middle iterations and three inner iterations per visit, with fixed bytecode counts per region. It then reads back the inner and middle global counters, which must be 102 and 120. Saturation is reached by preloading a global counter to a few counts below all ones through the host port before a run.

// File: rtl/loop_nest_profiler.sv
module loop_nest_profiler #(
  parameter int LOG_ENTRIES = 3,
  parameter int ADDR_W      = 16,
  parameter int CNT_W       = 32,
  localparam int ENTRIES    = 1 << LOG_ENTRIES,
  localparam int IDX_W      = LOG_ENTRIES + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   prof_en,
  input  logic                   fetch_valid,
  input  logic [ADDR_W-1:0]      fetch_addr,
  input  logic                   cfg_we,
  input  logic [LOG_ENTRIES-1:0] cfg_idx,
  input  logic [2:0]             cfg_field,
  input  logic [CNT_W-1:0]       cfg_wdata,
  output logic [CNT_W-1:0]       cfg_rdata,
  output logic [CNT_W-1:0]       run_count,
  output logic [IDX_W-1:0]       cur_loop
);

  localparam logic [IDX_W-1:0] TOP_LEVEL = '1;

  logic [ADDR_W-1:0] start_q [ENTRIES];
  logic [ADDR_W-1:0] end_q   [ENTRIES];
  logic [IDX_W-1:0]  pred_q  [ENTRIES];
  logic [CNT_W-1:0]  local_q [ENTRIES];
  logic [CNT_W-1:0]  glob_q  [ENTRIES];
  logic [ENTRIES-1:0] valid_q;

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [IDX_W-1:0] cur_q, cur_n;

  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] a, input logic [CNT_W-1:0] b);
    logic [CNT_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[CNT_W] ? '1 : s[CNT_W-1:0];
  endfunction

  logic [ENTRIES-1:0] match;
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cam
    assign match[g] = valid_q[g] && (start_q[g] == fetch_addr);
  end

  logic [LOG_ENTRIES-1:0] hit_idx;
  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (match[i]) hit_idx = LOG_ENTRIES'(i);
  end

  wire                   hit      = |match;
  wire [IDX_W-1:0]       hit_ext  = {1'b0, hit_idx};
  wire                   cur_act  = cur_q != TOP_LEVEL;
  wire [LOG_ENTRIES-1:0] cur_i    = cur_q[LOG_ENTRIES-1:0];
  wire [IDX_W-1:0]       up       = pred_q[cur_i];
  wire                   up_act   = up != TOP_LEVEL;
  wire                   go       = prof_en && fetch_valid;
  wire                   in_range = (fetch_addr >= start_q[cur_i]) && (fetch_addr <= end_q[cur_i]);
  wire                   leaving  = go && cur_act && !in_range;
  wire                   entering = go && !leaving && hit && (pred_q[hit_idx] == cur_q) && (hit_ext != cur_q);

  wire [CNT_W-1:0] parked  = up_act ? local_q[up[LOG_ENTRIES-1:0]] : '0;
  wire [CNT_W-1:0] restore = sat_add(sat_add(cnt_q, parked), CNT_W'(1));

  always_comb begin
    cnt_n = cnt_q;
    cur_n = cur_q;
    if (!prof_en) begin
      cnt_n = '0;
      cur_n = TOP_LEVEL;
    end else if (leaving) begin
      cnt_n = restore;
      cur_n = up;
    end else if (entering) begin
      cnt_n = CNT_W'(1);
      cur_n = hit_ext;
    end else if (go) begin
      cnt_n = sat_add(cnt_q, CNT_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cur_q <= TOP_LEVEL;
    end else begin
      cnt_q <= cnt_n;
      cur_q <= cur_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        start_q[i] <= '0;
        end_q[i]   <= '0;
        pred_q[i]  <= TOP_LEVEL;
        local_q[i] <= '0;
        glob_q[i]  <= '0;
      end
    end else if (!prof_en) begin
      if (cfg_we) begin
        case (cfg_field)
          3'd0: start_q[cfg_idx] <= cfg_wdata[ADDR_W-1:0];
          3'd1: end_q[cfg_idx]   <= cfg_wdata[ADDR_W-1:0];
          3'd2: pred_q[cfg_idx]  <= cfg_wdata[IDX_W-1:0];
          3'd3: local_q[cfg_idx] <= cfg_wdata;
          3'd4: glob_q[cfg_idx]  <= cfg_wdata;
          3'd5: valid_q[cfg_idx] <= cfg_wdata[0];
          default: ;
        endcase
      end
    end else begin
      if (leaving) glob_q[cur_i] <= sat_add(glob_q[cur_i], cnt_q);
      if (entering && cur_act) local_q[cur_i] <= cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_rdata <= '0;
    else begin
      case (cfg_field)
        3'd0:    cfg_rdata <= CNT_W'(start_q[cfg_idx]);
        3'd1:    cfg_rdata <= CNT_W'(end_q[cfg_idx]);
        3'd2:    cfg_rdata <= CNT_W'(pred_q[cfg_idx]);
        3'd3:    cfg_rdata <= local_q[cfg_idx];
        3'd4:    cfg_rdata <= glob_q[cfg_idx];
        3'd5:    cfg_rdata <= CNT_W'(valid_q[cfg_idx]);
        default: cfg_rdata <= '0;
      endcase
    end
  end

  assign run_count = cnt_q;
  assign cur_loop  = cur_q;

endmodule

// File: rtl/loop_nest_profiler_chk.sv
module loop_nest_profiler_chk #(
  parameter int CNT_W = 32,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             prof_en,
  input logic             fetch_valid,
  input logic [CNT_W-1:0] run_count,
  input logic [IDX_W-1:0] cur_loop
);

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !prof_en |=> (run_count == '0 && cur_loop == '1));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (prof_en && !fetch_valid) |=> ($stable(run_count) && $stable(cur_loop)));

  assert_fetch_counts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (prof_en && fetch_valid) |=> (run_count != '0));

  assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (prof_en && fetch_valid) |=>
      (run_count == CNT_W'(1) || run_count == '1 || run_count > $past(run_count)));

endmodule

bind loop_nest_profiler loop_nest_profiler_chk #(.CNT_W(CNT_W), .IDX_W(IDX_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .prof_en(prof_en), .fetch_valid(fetch_valid),
  .run_count(run_count), .cur_loop(cur_loop)
);

// File: tb/loop_nest_profiler_tb_top.sv
module loop_nest_profiler_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prof_en = 1'b0;
  logic        fetch_valid = 1'b0;
  logic [15:0] fetch_addr = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [2:0]  cfg_field = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [31:0] run_count;
  logic [3:0]  cur_loop;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  loop_nest_profiler dut_i (
    .clk(clk), .rst_n(rst_n), .prof_en(prof_en), .fetch_valid(fetch_valid),
    .fetch_addr(fetch_addr), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_field(cfg_field),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .run_count(run_count), .cur_loop(cur_loop)
  );

  typedef struct packed {
    logic [15:0] addr;
    logic [31:0] cnt;
    logic [3:0]  cur;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{16'h00, 32'd1,  4'hF},
    '{16'h01, 32'd2,  4'hF},
    '{16'h10, 32'd1,  4'h0},
    '{16'h11, 32'd2,  4'h0},
    '{16'h10, 32'd3,  4'h0},
    '{16'h30, 32'd4,  4'h0},
    '{16'h20, 32'd1,  4'h1},
    '{16'h21, 32'd2,  4'h1},
    '{16'h30, 32'd1,  4'h2},
    '{16'h31, 32'd2,  4'h2},
    '{16'h30, 32'd3,  4'h2},
    '{16'h41, 32'd6,  4'h1},
    '{16'h46, 32'd11, 4'h0},
    '{16'h00, 32'd12, 4'hF}
  };

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [2:0] idx, input logic [2:0] fld, input logic [31:0] d);
    cfg_we = 1'b1; cfg_idx = idx; cfg_field = fld; cfg_wdata = d;
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_rd(input logic [2:0] idx, input logic [2:0] fld, output logic [31:0] d);
    cfg_idx = idx; cfg_field = fld;
    @(posedge clk); @(negedge clk);
    d = cfg_rdata;
  endtask

  task automatic load_loop(input logic [2:0] idx, input logic [15:0] s, input logic [15:0] e, input logic [3:0] p);
    cfg_wr(idx, 3'd0, 32'(s));
    cfg_wr(idx, 3'd1, 32'(e));
    cfg_wr(idx, 3'd2, 32'(p));
    cfg_wr(idx, 3'd5, 32'd1);
  endtask

  task automatic fetch(input logic [15:0] a);
    fetch_valid = 1'b1; fetch_addr = a;
    @(posedge clk); @(negedge clk);
    fetch_valid = 1'b0;
  endtask

  task automatic fetch_range(input logic [15:0] lo, input logic [15:0] hi);
    for (int a = int'(lo); a <= int'(hi); a++) fetch(16'(a));
  endtask

  task automatic idle_cycle();
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    check("R12 run_count after reset", run_count, 32'd0);
    check("R12 cur_loop after reset", 32'(cur_loop), 32'hF);
    cfg_rd(3'd0, 3'd4, d); check("R12 global counter after reset", d, 32'd0);
    cfg_rd(3'd2, 3'd2, d); check("R12 pred after reset", d, 32'hF);

    load_loop(3'd0, 16'h10, 16'h5B, 4'hF);
    load_loop(3'd1, 16'h20, 16'h45, 4'h0);
    load_loop(3'd2, 16'h30, 16'h40, 4'h1);
    cfg_rd(3'd1, 3'd0, d); check("R11 read start of entry 1", d, 32'h20);
    cfg_rd(3'd2, 3'd5, d); check("R11 read valid of entry 2", d, 32'd1);

    // Table walk: R2 plain counts, R3 entries, R4 iterations, R5 foreign hit, R6 exits, R7 method level
    prof_en = 1'b1;
    idle_cycle();
    for (int i = 0; i < NV; i++) begin
      fetch(VECS[i].addr);
      check($sformatf("R2 R3 R4 R5 R6 R7 step %0d run_count", i), run_count, VECS[i].cnt);
      check($sformatf("R3 R6 step %0d cur_loop", i), 32'(cur_loop), 32'(VECS[i].cur));
    end
    idle_cycle();
    check("R2 no strobe keeps count", run_count, 32'd12);

    prof_en = 1'b0;
    idle_cycle();
    check("R9 count cleared when disabled", run_count, 32'd0);
    check("R9 level reset when disabled", 32'(cur_loop), 32'hF);
    fetch(16'h10);
    check("R9 fetch ignored when disabled", run_count, 32'd0);
    check("R9 no entry when disabled", 32'(cur_loop), 32'hF);

    cfg_rd(3'd2, 3'd4, d); check("R6 inner global", d, 32'd3);
    cfg_rd(3'd1, 3'd4, d); check("R6 middle global", d, 32'd6);
    cfg_rd(3'd0, 3'd4, d); check("R6 outer global", d, 32'd11);
    cfg_rd(3'd0, 3'd3, d); check("R3 outer local parked", d, 32'd4);
    cfg_rd(3'd1, 3'd3, d); check("R3 middle local parked", d, 32'd2);

    prof_en = 1'b1;
    cfg_wr(3'd0, 3'd4, 32'd123);
    prof_en = 1'b0;
    idle_cycle();
    cfg_rd(3'd0, 3'd4, d); check("R10 write ignored while enabled", d, 32'd11);

    // R1: invalid entry never matches
    cfg_wr(3'd0, 3'd5, 32'd0);
    prof_en = 1'b1;
    fetch(16'h10);
    check("R1 invalid entry no hit count", run_count, 32'd1);
    check("R1 invalid entry no hit level", 32'(cur_loop), 32'hF);
    prof_en = 1'b0;
    idle_cycle();
    cfg_wr(3'd0, 3'd5, 32'd1);

    // R1: lowest index wins among equal start addresses
    load_loop(3'd3, 16'h10, 16'h12, 4'hF);
    prof_en = 1'b1;
    fetch(16'h10);
    check("R1 lowest index wins", 32'(cur_loop), 32'h0);
    prof_en = 1'b0;
    idle_cycle();
    cfg_wr(3'd3, 3'd5, 32'd0);

    // R8: global counter saturates
    cfg_wr(3'd2, 3'd4, 32'hFFFF_FFF0);
    prof_en = 1'b1;
    fetch(16'h10);
    fetch(16'h20);
    fetch_range(16'h30, 16'h40);
    check("R3 inner count before exit", run_count, 32'd17);
    fetch(16'h41);
    check("R6 restore after exit", run_count, 32'd19);
    prof_en = 1'b0;
    idle_cycle();
    cfg_rd(3'd2, 3'd4, d); check("R8 global saturates", d, 32'hFFFF_FFFF);

    // Worked nest: two middle iterations, three inner iterations per visit
    for (int k = 0; k < 3; k++) begin
      cfg_wr(3'(k), 3'd3, 32'd0);
      cfg_wr(3'(k), 3'd4, 32'd0);
    end
    prof_en = 1'b1;
    fetch_range(16'h10, 16'h13);
    for (int m = 0; m < 2; m++) begin
      fetch_range(16'h20, 16'h23);
      for (int n = 0; n < 3; n++) fetch_range(16'h30, 16'h40);
      fetch_range(16'h41, 16'h45);
    end
    check("R6 middle level before exit", run_count, 32'd120);
    fetch(16'h46);
    check("R6 restore to outer", run_count, 32'd125);
    check("R6 back to outer", 32'(cur_loop), 32'h0);
    fetch_range(16'h47, 16'h5B);
    check("R2 outer tail count", run_count, 32'd146);
    fetch(16'h00);
    check("R7 exit to method level", run_count, 32'd147);
    check("R7 method level index", 32'(cur_loop), 32'hF);
    prof_en = 1'b0;
    idle_cycle();
    cfg_rd(3'd2, 3'd4, d); check("R6 nest inner global", d, 32'd102);
    cfg_rd(3'd1, 3'd4, d); check("R6 nest middle global", d, 32'd120);
    cfg_rd(3'd1, 3'd3, d); check("R3 nest middle local", d, 32'd64);
    cfg_rd(3'd0, 3'd4, d); check("R6 nest outer global", d, 32'd146);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule